// File: doc/BRIEF.md
# DTE Synchronous Serial Clocking Port

This block connects a terminal's serial bit lines to the bit streams of a modem datapump. It produces the transmit clock that the terminal uses. That clock comes from one of three sources: a free-running divider of the system clock, a digital phase lock to a clock that the terminal supplies, or a phase lock to the receive clock. The block then captures each transmit bit and hands it to the datapump together with a one-cycle strobe. For asynchronous traffic, the transmit line bypasses the capture stage entirely.

On the receive side, the datapump delivers recovered bits with a one-cycle strobe. The block presents each bit on the receive data line and builds a receive clock around it. The clock falls as the bit changes and rises half a bit later. Both lines depend on carrier: with no carrier, the data line rests at mark and the clock stays low. The phase lock counts system clocks per bit and moves the next bit boundary by one count per bit, so it follows a reference a few percent away from the nominal rate. The source can be switched at any time without a short clock phase.

Top module: `dte_sync_port`

## Requirements
- R1: After reset, tx_clk is 0, rx_clk is 0, rx_data is 1 and dp_tx_stb is 0.
- R2: With clk_src 00, or the spare code 11, tx_clk is free-running. Its period is DIV_FAST system clocks when rate_slow is 0 and DIV_SLOW when rate_slow is 1. A rate change takes effect at the next bit boundary.
- R3: In synchronous operation with clk_src 00 or 10, each tx_clk rising edge captures the synchronized tx_data. The captured value appears on dp_tx_bit together with a one-cycle dp_tx_stb pulse, one cycle after the tx_clk rise is visible.
- R4: With clk_src 01, tx_clk locks to ext_clk within 70 bit periods. Lock holds for a reference period of DIV_FAST and of DIV_FAST±1 system clocks. Once locked, each tx_clk rise lies within 6 system clocks of an ext_clk rise, and each tx_clk period is within one count of the reference period.
- R5: With clk_src 01, capture is triggered by the synchronized ext_clk rising edge. dp_tx_stb is seen SYNC_STAGES+1 cycles after ext_clk rises, and it carries the tx_data value.
- R6: With clk_src 10 and carrier present, tx_clk locks to rx_clk. The same 6-clock window applies, for receive bit periods of DIV_FAST and DIV_FAST+1.
- R7: While carrier_ok is 0, rx_data is 1 (mark) and rx_clk is 0 from the next clock edge, and receive strobes have no effect.
- R8: While carrier_ok is 1, a dp_rx_stb loads dp_rx_bit into rx_data and drives rx_clk low on the same edge. rx_clk then rises DIV/2 edges later (half the nominal bit period), so rx_data never changes while rx_clk is high.
- R9: While async_en is 1, dp_tx_bit follows tx_data with no clock, and dp_tx_stb stays 0.
- R10: Every high or low phase of tx_clk lasts at least DIV_FAST/2-1 system clocks. This holds across source switches and rate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| clk_src | input | 2 | Transmit clock source: 00 divider, 01 external, 10 slave, 11 divider |
| rate_slow | input | 1 | 0: nominal period DIV_FAST, 1: DIV_SLOW |
| async_en | input | 1 | 1: pass tx_data straight through |
| ext_clk | input | 1 | Terminal-supplied clock, asynchronous |
| tx_data | input | 1 | Serial transmit data from the terminal |
| carrier_ok | input | 1 | Carrier detect from the datapump |
| dp_rx_stb | input | 1 | One-cycle pulse marking a new recovered bit |
| dp_rx_bit | input | 1 | Recovered receive bit |
| tx_clk | output | 1 | Transmit clock to the terminal |
| dp_tx_bit | output | 1 | Transmit bit to the datapump |
| dp_tx_stb | output | 1 | One-cycle pulse per captured transmit bit |
| rx_clk | output | 1 | Receive clock to the terminal |
| rx_data | output | 1 | Receive data to the terminal |

## Verification
The phase lock is driven with external references at the nominal period and at one count slower and faster. These runs separate a loop that truly tracks from one that only free-runs at the nominal rate. Slave locking uses receive strobes at two periods, which shows that the reference really follows the selected source. A table of receive bits with carrier toggled shows loading, the half-bit clock rise, and mark idling. Alternating transmit values, the strobe-to-edge gap, mid-run source and rate switches, and asynchronous mode tell apart sampling on the wrong edge, short clock phases and an unwanted capture.

// File: rtl/dte_port_pkg.sv
package dte_port_pkg;
    typedef enum logic [1:0] {
        SRC_LOCAL = 2'b00,
        SRC_TERM  = 2'b01,
        SRC_RECOV = 2'b10,
        SRC_SPARE = 2'b11
    } tx_src_e;

    typedef enum logic [1:0] {
        TRIM_NONE  = 2'b00,
        TRIM_SHORT = 2'b01,
        TRIM_LONG  = 2'b10
    } trim_e;
endpackage

// File: rtl/dte_sync_flop.sv
module dte_sync_flop #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
endmodule

// File: rtl/dte_txclk_dpll.sv
module dte_txclk_dpll import dte_port_pkg::*; #(
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_slow,
    input  logic ref_en,
    input  logic ref_rise,
    output logic tx_clk,
    output logic tx_rise
);
    localparam int CW = $clog2(DIV_SLOW + 1);
    localparam logic [CW-1:0] P_FAST     = CW'(DIV_FAST);
    localparam logic [CW-1:0] P_SLOW     = CW'(DIV_SLOW);
    localparam logic [CW-1:0] RUN_MAX    = '1;
    localparam logic [CW-1:0] RUN_FLOOR  = CW'(DIV_FAST / 2 - 2);

    typedef struct packed {
        logic [CW-1:0] cnt;
        trim_e         trim;
        logic          slow;
        logic          clk_lvl;
        logic          rise;
        logic [CW-1:0] run;
    } dpll_st_t;

    dpll_st_t      st_d, st_q;
    logic [CW-1:0] period, half, wrap_at;

    always_comb begin
        period = st_q.slow ? P_SLOW : P_FAST;
        half   = period >> 1;
        case (st_q.trim)
            TRIM_SHORT: wrap_at = period - CW'(2);
            TRIM_LONG:  wrap_at = period;
            default:    wrap_at = period - CW'(1);
        endcase

        st_d = st_q;
        // Bit boundary: restart the count and pick up a new rate here only
        if (st_q.cnt >= wrap_at) begin
            st_d.cnt  = '0;
            st_d.trim = TRIM_NONE;
            st_d.slow = rate_slow;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
        // Phase detector: the reference edge against our own rising point
        if (ref_en && ref_rise) begin
            if (st_q.cnt < half)      st_d.trim = TRIM_SHORT;
            else if (st_q.cnt > half) st_d.trim = TRIM_LONG;
            else                      st_d.trim = TRIM_NONE;
        end
        st_d.clk_lvl = (st_d.cnt >= half);
        st_d.rise    = st_d.clk_lvl & ~st_q.clk_lvl;
        if (st_d.clk_lvl != st_q.clk_lvl) st_d.run = '0;
        else if (st_q.run != RUN_MAX)     st_d.run = st_q.run + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.trim <= TRIM_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_clk  = st_q.clk_lvl;
    assign tx_rise = st_q.rise;

    // R10: a phase of tx_clk never ends before DIV_FAST/2-1 cycles
    assert_min_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clk_lvl != $past(st_q.clk_lvl)) |-> ($past(st_q.run) >= RUN_FLOOR));
endmodule

// File: rtl/dte_rxclk_gen.sv
module dte_rxclk_gen #(
    parameter int DIV_FAST = 32,
    parameter int DIV_SLOW = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rate_slow,
    input  logic carrier,
    input  logic bit_stb,
    input  logic bit_in,
    output logic rx_bit,
    output logic rx_clk,
    output logic rx_rise
);
    localparam int CW = $clog2(DIV_SLOW + 1);
    localparam logic [CW-1:0] H_FAST = CW'(DIV_FAST / 2);
    localparam logic [CW-1:0] H_SLOW = CW'(DIV_SLOW / 2);

    typedef struct packed {
        logic          bit_lvl;
        logic          clk_lvl;
        logic          rise;
        logic [CW-1:0] cnt;
    } rx_st_t;

    rx_st_t        st_d, st_q;
    logic [CW-1:0] half;

    always_comb begin
        half = rate_slow ? H_SLOW : H_FAST;
        st_d = st_q;
        if (!carrier) begin
            st_d.bit_lvl = 1'b1;
            st_d.clk_lvl = 1'b0;
            st_d.cnt     = '0;
        end else if (bit_stb) begin
            st_d.bit_lvl = bit_in;
            st_d.clk_lvl = 1'b0;
            st_d.cnt     = '0;
        end else if (st_q.cnt < half) begin
            st_d.cnt = st_q.cnt + CW'(1);
            if ((st_q.cnt + CW'(1)) == half) st_d.clk_lvl = 1'b1;
        end
        st_d.rise = st_d.clk_lvl & ~st_q.clk_lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.bit_lvl <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_bit  = st_q.bit_lvl;
    assign rx_clk  = st_q.clk_lvl;
    assign rx_rise = st_q.rise;

    // R7: with no carrier the outputs rest at mark with the clock low
    assert_idle_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !carrier |=> (st_q.bit_lvl && !st_q.clk_lvl));
    // R8: data moves only while the receive clock is low
    assert_bit_moves_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.bit_lvl) |-> !st_q.clk_lvl);
endmodule

// File: rtl/dte_sync_port.sv
module dte_sync_port import dte_port_pkg::*; #(
    parameter int DIV_FAST    = 32,
    parameter int DIV_SLOW    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] clk_src,
    input  logic       rate_slow,
    input  logic       async_en,
    input  logic       ext_clk,
    input  logic       tx_data,
    input  logic       carrier_ok,
    input  logic       dp_rx_stb,
    input  logic       dp_rx_bit,
    output logic       tx_clk,
    output logic       dp_tx_bit,
    output logic       dp_tx_stb,
    output logic       rx_clk,
    output logic       rx_data
);
    typedef struct packed {
        logic ext_prev;
        logic bit_lvl;
        logic stb;
    } smp_st_t;

    tx_src_e src;
    logic    ext_lvl, txd_lvl, ext_rise, tx_rise_w, rx_rise_w;
    logic    ref_en, ref_rise, pick;
    smp_st_t s_d, s_q;

    assign src = tx_src_e'(clk_src);

    dte_sync_flop #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk(clk), .rst_n(rst_n), .async_in(ext_clk), .sync_out(ext_lvl));

    dte_sync_flop #(.STAGES(SYNC_STAGES)) u_txd_sync (
        .clk(clk), .rst_n(rst_n), .async_in(tx_data), .sync_out(txd_lvl));

    dte_txclk_dpll #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_dpll (
        .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .ref_en(ref_en),
        .ref_rise(ref_rise), .tx_clk(tx_clk), .tx_rise(tx_rise_w));

    dte_rxclk_gen #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_rxgen (
        .clk(clk), .rst_n(rst_n), .rate_slow(rate_slow), .carrier(carrier_ok),
        .bit_stb(dp_rx_stb), .bit_in(dp_rx_bit), .rx_bit(rx_data),
        .rx_clk(rx_clk), .rx_rise(rx_rise_w));

    always_comb begin
        ext_rise = ext_lvl & ~s_q.ext_prev;
        ref_en   = (src == SRC_TERM) || (src == SRC_RECOV);
        ref_rise = (src == SRC_TERM) ? ext_rise : rx_rise_w;
        pick     = (src == SRC_TERM) ? ext_rise : tx_rise_w;

        s_d          = s_q;
        s_d.ext_prev = ext_lvl;
        s_d.stb      = 1'b0;
        if (!async_en && pick) begin
            s_d.bit_lvl = txd_lvl;
            s_d.stb     = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{ext_prev: 1'b0, bit_lvl: 1'b1, stb: 1'b0};
        else        s_q <= s_d;
    end

    assign dp_tx_bit = async_en ? tx_data : s_q.bit_lvl;
    assign dp_tx_stb = s_q.stb;

    // R9: no capture strobe while the bypass has been on for a full cycle
    assert_async_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (async_en && $past(async_en)) |-> !dp_tx_stb);
    // R3: a strobed bit equals the synchronized line one cycle earlier
    assert_sample_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_tx_stb && !async_en) |-> (dp_tx_bit == $past(txd_lvl)));
endmodule

// File: tb/dte_sync_port_bench.sv
module dte_sync_port_bench;
    localparam int CLK_PERIOD  = 10;
    localparam int DIV_FAST    = 32;
    localparam int DIV_SLOW    = 64;
    localparam int SYNC_STAGES = 2;
    localparam int HALF        = DIV_FAST / 2;
    // {carrier, bit}
    localparam logic [1:0] RX_VEC [0:7] = '{2'b11, 2'b10, 2'b11, 2'b00,
                                           2'b01, 2'b10, 2'b10, 2'b11};

    logic clk = 1'b0, rst_n = 1'b0;
    logic [1:0] clk_src = 2'b00;
    logic rate_slow = 0, async_en = 0, ext_clk = 0, tx_data = 0, carrier_ok = 0;
    logic man_stb = 0, man_bit = 1, gen_stb = 0, gen_bit = 1, gen_on = 0, ext_on = 0;
    logic dp_rx_stb, dp_rx_bit;
    logic tx_clk, dp_tx_bit, dp_tx_stb, rx_clk, rx_data;
    int   ext_p = 32, rx_p = 32;

    assign dp_rx_stb = gen_on ? gen_stb : man_stb;
    assign dp_rx_bit = gen_on ? gen_bit : man_bit;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dte_sync_port #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW), .SYNC_STAGES(SYNC_STAGES)) u_dte_sync_port (
        .clk(clk), .rst_n(rst_n), .clk_src(clk_src), .rate_slow(rate_slow),
        .async_en(async_en), .ext_clk(ext_clk), .tx_data(tx_data),
        .carrier_ok(carrier_ok), .dp_rx_stb(dp_rx_stb), .dp_rx_bit(dp_rx_bit),
        .tx_clk(tx_clk), .dp_tx_bit(dp_tx_bit), .dp_tx_stb(dp_tx_stb),
        .rx_clk(rx_clk), .rx_data(rx_data));

    int n_chk = 0, n_fail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Monitor, sampled at the falling edge
    logic ext_prev = 0, rx_prev = 0, tx_prev = 0, run_on = 0;
    int ext_rise_cyc = 0, rx_rise_cyc = 0, tx_rise_cyc = 0;
    int tx_period = 0, d_ext = 0, d_rx = 0, stb_cnt = 0, stb_ext_gap = 0, stb_tx_gap = 0;
    int run = 0, min_run = 1000;

    always @(negedge clk) begin
        if (ext_clk && !ext_prev) ext_rise_cyc = cyc;
        ext_prev = ext_clk;
        if (rx_clk && !rx_prev) rx_rise_cyc = cyc;
        rx_prev = rx_clk;
        if (tx_clk != tx_prev) begin
            if (tx_clk) begin
                tx_period   = cyc - tx_rise_cyc;
                tx_rise_cyc = cyc;
                d_ext       = cyc - ext_rise_cyc;
                d_rx        = cyc - rx_rise_cyc;
            end
            if (run_on && run < min_run) min_run = run;
            run = 1;
        end else begin
            run++;
        end
        tx_prev = tx_clk;
        if (dp_tx_stb) begin
            stb_cnt++;
            stb_ext_gap = cyc - ext_rise_cyc;
            stb_tx_gap  = cyc - tx_rise_cyc;
        end
    end

    // Terminal clock source
    initial forever begin
        if (ext_on) begin
            ext_clk = 1'b1;
            repeat (ext_p / 2) tick();
            ext_clk = 1'b0;
            repeat (ext_p - ext_p / 2) tick();
        end else begin
            tick();
        end
    end

    // Periodic receive strobes from the datapump
    initial forever begin
        if (gen_on) begin
            gen_stb = 1'b1;
            gen_bit = ~gen_bit;
            tick();
            gen_stb = 1'b0;
            repeat (rx_p - 1) tick();
        end else begin
            tick();
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
        summary();
        $finish;
    end

    task automatic wait_tx_rise();
        wait (!tx_clk);
        wait (tx_clk);
        @(negedge clk);
        #1;
    endtask

    task automatic wait_stb();
        wait (!dp_tx_stb);
        wait (dp_tx_stb);
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (5) tick();
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1 reset state
        chk(tx_clk == 1'b0, "R1 tx_clk", int'(tx_clk), 0);
        chk(rx_clk == 1'b0, "R1 rx_clk", int'(rx_clk), 0);
        chk(rx_data == 1'b1, "R1 rx_data", int'(rx_data), 1);
        chk(dp_tx_stb == 1'b0, "R1 dp_tx_stb", int'(dp_tx_stb), 0);
        run_on = 1'b1;

        // R2 free-running divider periods
        repeat (4 * DIV_FAST) tick();
        wait_tx_rise();
        chk(tx_period == DIV_FAST, "R2 fast period", tx_period, DIV_FAST);
        rate_slow = 1'b1;
        repeat (5 * DIV_SLOW) tick();
        wait_tx_rise();
        chk(tx_period == DIV_SLOW, "R2 slow period", tx_period, DIV_SLOW);
        clk_src = 2'b11;
        repeat (3 * DIV_SLOW) tick();
        wait_tx_rise();
        chk(tx_period == DIV_SLOW, "R2 spare code period", tx_period, DIV_SLOW);
        rate_slow = 1'b0;
        clk_src   = 2'b00;
        repeat (4 * DIV_SLOW) tick();
        wait_tx_rise();
        chk(tx_period == DIV_FAST, "R2 back to fast", tx_period, DIV_FAST);

        // R3 capture on the transmit clock
        for (int v = 0; v < 3; v++) begin
            tx_data = (v % 2 == 0);
            wait_stb();
            wait_stb();
            chk(dp_tx_bit == tx_data, "R3 captured bit", int'(dp_tx_bit), int'(tx_data));
            chk(stb_tx_gap == 1, "R3 strobe after tx_clk rise", stb_tx_gap, 1);
        end

        // R4 lock to the terminal clock at nominal and off-nominal periods
        ext_on = 1'b1;
        clk_src = 2'b01;
        for (int k = 0; k < 3; k++) begin
            ext_p = (k == 0) ? DIV_FAST : (k == 1) ? DIV_FAST - 1 : DIV_FAST + 1;
            repeat (70 * ext_p) tick();
            wait_tx_rise();
            chk(d_ext <= 6 || d_ext >= ext_p - 2, "R4 phase to ext_clk", d_ext, 3);
            wait_tx_rise();
            chk(tx_period >= ext_p - 1 && tx_period <= ext_p + 1, "R4 tracked period", tx_period, ext_p);
        end

        // R5 capture on the external clock edge
        ext_p = DIV_FAST;
        repeat (4 * DIV_FAST) tick();
        for (int v = 0; v < 2; v++) begin
            tx_data = (v == 0);
            wait_stb();
            wait_stb();
            chk(dp_tx_bit == tx_data, "R5 captured bit", int'(dp_tx_bit), int'(tx_data));
            chk(stb_ext_gap == SYNC_STAGES + 1, "R5 strobe gap", stb_ext_gap, SYNC_STAGES + 1);
        end

        // R6 slave lock to the receive clock
        carrier_ok = 1'b1;
        gen_on     = 1'b1;
        clk_src    = 2'b10;
        for (int k = 0; k < 2; k++) begin
            rx_p = DIV_FAST + k;
            repeat (70 * rx_p) tick();
            wait_tx_rise();
            chk(d_rx <= 6 || d_rx >= rx_p - 2, "R6 phase to rx_clk", d_rx, 3);
        end

        // R10 source and rate switches mid-period
        for (int k = 0; k < 6; k++) begin
            clk_src = 2'(k % 3);
            if (k == 3) rate_slow = 1'b1;
            repeat (37) tick();
        end
        rate_slow = 1'b0;
        clk_src   = 2'b00;
        repeat (3 * DIV_SLOW) tick();
        chk(min_run >= HALF - 1, "R10 shortest tx_clk phase", min_run, HALF - 1);

        // R7 / R8 receive table
        gen_on = 1'b0;
        for (int i = 0; i < 8; i++) begin
            carrier_ok = RX_VEC[i][1];
            man_bit    = RX_VEC[i][0];
            man_stb    = 1'b1;
            tick();
            man_stb = 1'b0;
            @(negedge clk);
            #1;
            chk(rx_data == (RX_VEC[i][1] ? RX_VEC[i][0] : 1'b1),
                RX_VEC[i][1] ? "R8 loaded bit" : "R7 idle mark", int'(rx_data),
                int'(RX_VEC[i][1] ? RX_VEC[i][0] : 1'b1));
            chk(rx_clk == 1'b0, "R8 rx_clk low at load", int'(rx_clk), 0);
            repeat (HALF - 1) tick();
            @(negedge clk);
            #1;
            chk(rx_clk == 1'b0, "R8 rx_clk before half bit", int'(rx_clk), 0);
            tick();
            @(negedge clk);
            #1;
            chk(rx_clk == RX_VEC[i][1], "R7 R8 rx_clk at half bit", int'(rx_clk), int'(RX_VEC[i][1]));
        end

        // R9 asynchronous bypass
        async_en = 1'b1;
        tx_data  = 1'b0;
        #1;
        chk(dp_tx_bit == 1'b0, "R9 pass-through 0", int'(dp_tx_bit), 0);
        tx_data = 1'b1;
        #1;
        chk(dp_tx_bit == 1'b1, "R9 pass-through 1", int'(dp_tx_bit), 1);
        tick();
        stb_cnt = 0;
        repeat (100) tick();
        chk(stb_cnt == 0, "R9 no strobes", stb_cnt, 0);

        summary();
        $finish;
    end
endmodule